// File: doc/BRIEF.md
# Framed Serial Word Bypass Between Independent Ports

This block moves one word per frame from a framed serial input port to a framed serial output port, where the two ports run on unrelated bit clocks and frame syncs. A single fast system clock samples every serial line through a two-flop chain and finds its edges, so the whole block sits in one clock domain. On the input side, a rising frame sync arms a deserializer. It samples data on the falling edges of the bit clock, MSB first. On the eighth such edge it latches the word into a holding register.

On the output side, each rising edge of the frame sync loads the output shifter in parallel. The shifter then presents one bit per output bit period, changing on the rising edge of the bit clock. In bypass mode it sends the held 8-bit word unchanged. In normal mode it sends a 4-bit code taken from a parallel input. Once the last bit has been sent, the output enable drops and the data line floats high, as an open-drain line with a pull-up would.

The two ports have no fixed phase relation. An output load can therefore reuse a word that was already sent, and a new latch can overwrite a word that was never sent. The block flags both cases with a one-cycle pulse.

Top module: `slot_bypass`

## Requirements
- R1: In bypass mode, the 8 bits received after an input frame sync are sent on the output port in the same MSB-first order, with no change.
- R2: The input word is captured at the 8th falling edge of the input bit clock after the input frame sync rises. Input data in later bit periods of the frame has no effect on any word that is sent.
- R3: An output frame sync rising edge loads the most recently captured word. When the load and the capture fall in the same system clock cycle, the load takes the word captured before that one.
- R4: In normal mode, the output sends the 4-bit value on `nib_in` as it was at the load, MSB first.
- R5: The first bit is presented from the output frame sync rising edge. Each following bit replaces it on a rising edge of the output bit clock. Between those events, `out_sdo` and `out_oe` hold.
- R6: `out_oe` is 1 for exactly 8 output bit periods in bypass mode and 4 in normal mode, and 0 from then until the next load. While `out_oe` is 0, `out_sdo` is 1.
- R7: The mode is taken from `bypass` (1 = bypass, 0 = normal) only at the load. Changing it while a word is being sent does not affect that word.
- R8: `slip_o` pulses for one system clock cycle when a capture replaces a word that was never loaded. It also pulses when a bypass-mode load finds no new capture since the previous load. It never pulses otherwise. The pulse comes at the same fixed latency as the other outputs.
- R9: After reset, `out_oe`=0, `out_sdo`=1 and `slip_o`=0. The held word is 0x00, and it counts as already loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst | input | 1 | Synchronous active-high reset |
| in_bclk | input | 1 | Input port bit clock |
| in_sync | input | 1 | Input port frame sync |
| in_sdi | input | 1 | Input port serial data |
| out_bclk | input | 1 | Output port bit clock |
| out_sync | input | 1 | Output port frame sync |
| bypass | input | 1 | 1 = send the 8-bit word unchanged, 0 = send the 4-bit code |
| nib_in | input | NIB_W | 4-bit code sent in normal mode |
| out_sdo | output | 1 | Output serial data, 1 when released |
| out_oe | output | 1 | Output drive enable |
| slip_o | output | 1 | One-cycle pulse on a dropped or repeated word |

## Verification
Several frame timings are used, and each one separates a different behaviour:
- An output sync placed well after the input capture point shows the word passing through in the same frame.
- An output sync placed before the capture point shows the one-frame delay and the initial 0x00 word.
- An output sync placed on exactly the capture cycle shows that the older word is chosen on a tie.
- Two frame periods that differ slightly make the relative phase drift across the capture point, which forces a repeat and shows the slip pulse.
- Random bit clock rates, frame lengths, offsets and mode changes in the middle of a word cover the rest.
- Random data driven in the unused input bit periods shows that those bits are ignored.

// File: rtl/slot_bypass_pkg.sv
package slot_bypass_pkg;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_BYPASS = 1'b1
    } mode_e;

    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sbp_edge_sync.sv
module sbp_edge_sync
    import slot_bypass_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  async_i,
    output edge_t ev_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_i};
    end

    always_comb begin
        ev_o.lvl  = chain[STAGES-1];
        ev_o.rise = chain[STAGES-1] & ~chain[STAGES];
        ev_o.fall = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/sbp_rx.sv
module sbp_rx
    import slot_bypass_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_strobe,
    input  logic              sdi,
    output logic              latch_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CW = count_width(WORD_W);

    logic              armed;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        sh_next = {sh[WORD_W-2:0], sdi};
        latch_o = armed && bit_strobe && !frame_start && (cnt == CW'(WORD_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            word_o <= '0;
        end else if (frame_start) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && bit_strobe) begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
            if (latch_o) begin
                word_o <= sh_next;
                armed  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sbp_tx.sv
module sbp_tx
    import slot_bypass_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  mode_e             mode_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic              sdo_o,
    output logic              oe_o
);
    localparam int CW  = count_width(WORD_W);
    localparam int PAD = WORD_W - NIB_W;

    logic [WORD_W-1:0] sh;
    logic [CW-1:0]     left;
    logic              oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
            oe   <= 1'b0;
        end else if (load_i) begin
            oe <= 1'b1;
            if (mode_i == MODE_BYPASS) begin
                sh   <= word_i;
                left <= CW'(WORD_W);
            end else begin
                sh   <= {nib_i, {PAD{1'b0}}};
                left <= CW'(NIB_W);
            end
        end else if (shift_i && oe) begin
            if (left == CW'(1)) begin
                oe   <= 1'b0;
                left <= '0;
            end else begin
                sh   <= {sh[WORD_W-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end

    assign sdo_o = oe ? sh[WORD_W-1] : 1'b1;
    assign oe_o  = oe;
endmodule

// File: rtl/slot_bypass.sv
module slot_bypass
    import slot_bypass_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_bclk,
    input  logic             in_sync,
    input  logic             in_sdi,
    input  logic             out_bclk,
    input  logic             out_sync,
    input  logic             bypass,
    input  logic [NIB_W-1:0] nib_in,
    output logic             out_sdo,
    output logic             out_oe,
    output logic             slip_o
);
    localparam int N_ASYNC = 5;
    localparam int IX_IBCK = 0;
    localparam int IX_ISYN = 1;
    localparam int IX_IDAT = 2;
    localparam int IX_OBCK = 3;
    localparam int IX_OSYN = 4;

    logic [N_ASYNC-1:0] raw;
    edge_t              ev [N_ASYNC];

    assign raw = {out_sync, out_bclk, in_sdi, in_sync, in_bclk};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        sbp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw[g]),
            .ev_o    (ev[g])
        );
    end

    logic              rx_latch;
    logic [WORD_W-1:0] rx_word;
    logic              tx_load;
    logic              ob_rise;
    logic              fresh;
    mode_e             mode;

    assign tx_load = ev[IX_OSYN].rise;
    assign ob_rise = ev[IX_OBCK].rise;
    assign mode    = bypass ? MODE_BYPASS : MODE_NORMAL;

    logic unused_edges;
    assign unused_edges = ^{ev[IX_IBCK].lvl, ev[IX_IBCK].rise, ev[IX_ISYN].lvl,
                            ev[IX_ISYN].fall, ev[IX_IDAT].rise, ev[IX_IDAT].fall,
                            ev[IX_OBCK].lvl, ev[IX_OBCK].fall, ev[IX_OSYN].lvl,
                            ev[IX_OSYN].fall};

    sbp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (ev[IX_ISYN].rise),
        .bit_strobe  (ev[IX_IBCK].fall),
        .sdi         (ev[IX_IDAT].lvl),
        .latch_o     (rx_latch),
        .word_o      (rx_word)
    );

    sbp_tx #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tx_load),
        .shift_i (ob_rise),
        .mode_i  (mode),
        .word_i  (rx_word),
        .nib_i   (nib_in),
        .sdo_o   (out_sdo),
        .oe_o    (out_oe)
    );

    // fresh: a captured word is waiting that no load has taken yet
    always_ff @(posedge clk) begin
        if (rst) begin
            fresh  <= 1'b0;
            slip_o <= 1'b0;
        end else begin
            slip_o <= (rx_latch && fresh && !tx_load) ||
                      (tx_load && (mode == MODE_BYPASS) && !fresh);
            if (rx_latch)     fresh <= 1'b1;
            else if (tx_load) fresh <= 1'b0;
        end
    end
endmodule

// File: rtl/slot_bypass_checker.sv
module slot_bypass_checker (
    input logic clk,
    input logic rst,
    input logic out_oe,
    input logic out_sdo,
    input logic slip_o,
    input logic load_ev,
    input logic shift_ev,
    input logic latch_ev
);
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_oe && out_sdo && !slip_o));

    assert_slip_single_R8: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o);

    assert_slip_cause_R8: assert property (@(posedge clk) disable iff (rst)
        slip_o |-> $past(latch_ev || load_ev));

    assert_oe_on_load_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_oe) |-> $past(load_ev));

    assert_released_high_R6: assert property (@(posedge clk) disable iff (rst)
        !out_oe |-> out_sdo);

    assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_ev && !shift_ev) |=> ($stable(out_sdo) && $stable(out_oe)));
endmodule

bind slot_bypass slot_bypass_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_oe   (out_oe),
    .out_sdo  (out_sdo),
    .slip_o   (slip_o),
    .load_ev  (tx_load),
    .shift_ev (ob_rise),
    .latch_ev (rx_latch)
);

// File: tb/sim_slot_bypass.sv
module sim_slot_bypass;
    logic       clk;
    logic       rst;
    logic       in_bclk, in_sync, in_sdi;
    logic       out_bclk, out_sync;
    logic       bypass;
    logic [3:0] nib_in;
    logic       out_sdo, out_oe, slip_o;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model state
    logic [7:0] m_lat, m_prev, a_word, exp_w;
    int         m_lat_cyc;
    bit         m_fresh;
    bit [2:0]   slip_pipe;
    int         exp_len;
    bit         frame_ok;

    slot_bypass u0 (
        .clk(clk), .rst(rst), .in_bclk(in_bclk), .in_sync(in_sync), .in_sdi(in_sdi),
        .out_bclk(out_bclk), .out_sync(out_sync), .bypass(bypass), .nib_in(nib_in),
        .out_sdo(out_sdo), .out_oe(out_oe), .slip_o(slip_o)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [7:0] w, input int len, input int i);
        return w[len-1-i];
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_bclk = 0; in_sync = 0; in_sdi = 0; out_bclk = 0; out_sync = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_lat = '0; m_prev = '0; m_lat_cyc = -1; m_fresh = 0;
        slip_pipe = '0; frame_ok = 0; exp_len = 0; exp_w = '0; a_word = '0;
        chk(!out_oe && out_sdo && !slip_o, "R9 reset state", {out_oe, out_sdo, slip_o}, 3'b010);
    endtask

    // bmode: 0 fixed normal, 1 fixed bypass, 2 random mode changes mid-word
    task automatic run_phase(input int ha, input int fa, input int hb, input int fbn,
                             input int at0, input int bt0, input int ncyc, input int bmode);
        bypass = (bmode == 1);
        nib_in = 4'($urandom);
        do_reset();
        for (int t = 0; t < ncyc; t++) begin
            bit lev, dev, snow;
            @(negedge clk);
            // slip event from cycle t-3 shows now (R8)
            if (slip_pipe[2] || slip_o)
                chk(slip_o == slip_pipe[2], "R8 slip pulse", slip_o, slip_pipe[2]);
            lev = 0; dev = 0;
            if (t >= at0) begin
                int u, k, ph, fb;
                u = t - at0; k = u / (2*ha); ph = u % (2*ha); fb = k % fa;
                in_bclk = (ph < ha);
                in_sync = (fb == 0);
                if (ph == 0) begin
                    if (fb == 0) a_word = 8'($urandom);
                    // bits after the 8th are random and must be ignored (R2)
                    in_sdi = (fb < 8) ? a_word[7-fb] : 1'($urandom);
                end
                if (ph == ha && fb == 7) begin
                    m_prev = m_lat; m_lat = a_word; m_lat_cyc = t; lev = 1;
                end
            end
            if (t >= bt0) begin
                int u, k, ph, fb;
                u = t - bt0; k = u / (2*hb); ph = u % (2*hb); fb = k % fbn;
                // midpoint checks observe the state of the current bit
                if (ph == hb && frame_ok) begin
                    if (fb < exp_len) begin
                        bit eb;
                        eb = exp_bit(exp_w, exp_len, fb);
                        chk(out_oe && (out_sdo == eb),
                            (exp_len == 8) ? "R1 R2 R3 R5 bypass bit" : "R4 R5 R7 normal bit",
                            {out_oe, out_sdo}, {1'b1, eb});
                    end else if (fb == exp_len) begin
                        chk(!out_oe && out_sdo, "R6 release", {out_oe, out_sdo}, 2'b01);
                    end
                end
                out_bclk = (ph < hb);
                out_sync = (fb == 0);
                if (ph == 0 && fb == 0) begin
                    dev = 1;
                    frame_ok = 1;
                    exp_len = bypass ? 8 : 4;
                    if (bypass) exp_w = (m_lat_cyc == t) ? m_prev : m_lat;
                    else        exp_w = {4'b0, nib_in};
                end
                if (ph == 0 && fb == 2) begin
                    nib_in = 4'($urandom);
                    if (bmode == 2) bypass = 1'($urandom);   // R7: changed mid-word
                end
            end
            snow = (lev && m_fresh && !dev) || (dev && (exp_len == 8) && !m_fresh);
            if (lev)      m_fresh = 1;
            else if (dev) m_fresh = 0;
            slip_pipe = {slip_pipe[1:0], snow};
        end
    endtask

    initial begin
        void'($urandom(32'h51ab));
        rst = 1'b1; bypass = 0; nib_in = 0;
        // load before capture: one-frame delay, first word 0x00 (R9, R3)
        run_phase(6, 16, 6, 16, 0, 40, 1200, 1);
        // load after capture: same-frame pass-through (R1)
        run_phase(6, 16, 6, 16, 0, 100, 1200, 1);
        // normal mode code (R4)
        run_phase(6, 16, 4, 24, 0, 100, 1200, 0);
        // load exactly on the capture cycle takes the older word (R3)
        run_phase(6, 16, 6, 16, 0, 90, 1200, 1);
        // drifting frame periods force a repeat (R8)
        run_phase(6, 16, 5, 19, 0, 100, 3000, 1);
        // random timing and modes
        for (int p = 0; p < 4; p++)
            run_phase(4 + int'($urandom % 5), 10 + int'($urandom % 11),
                      4 + int'($urandom % 5), 10 + int'($urandom % 11),
                      int'($urandom % 200), int'($urandom % 300), 3000, 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule